// File: doc/BRIEF.md
# Reshapeable Dual-Port RAM Block

This block is a 2,304-bit memory with one write port and one read port, each on its own clock. A two-bit organization input selects how the single storage array is seen from both ports. The four shapes are 128 words of 18 bits, 256 words of 9 bits, 512 words of 4 bits and 1024 words of 2 bits. Each port always presents a 10-bit address and an 18-bit data bus. Only the low address bits and the low data bits that the current shape needs are used.

Writes are captured on the write clock when the write enable is high. The read port has two styles, chosen by a control input. In registered style the read enable gates the load of an output register on the read clock. In flow-through style the read enable opens a combinational path from the read address to the output. When that path is closed, the output shows the value the read register last took.

The organization input is expected to stay put while the block is in use. Changing it leaves the stored bits alone and only changes how addresses and lanes map onto them. Storage is laid out as 128 rows of 18 bits. A word of the narrower shapes is a lane inside a row: the low address bits pick the lane and the next 7 bits pick the row.

Top module: `cfg_dpram`

## Requirements
- R1: While `rst_n` is low and after it rises, `rd_data` is 0 until the first read load.
- R2: `org` = 0, 1, 2, 3 selects 128x18, 256x9, 512x4 and 1024x2. A word written at an address in one shape reads back at that address in the same shape. The shape uses address bits [6+org:0] and data bits [W-1:0], where W = 18, 9, 4, 2.
- R3: Address bits above bit 6+org and write-data bits at or above W have no effect on what is stored.
- R4: In a read produced under the current shape, `rd_data` bits at or above W are 0.
- R5: Storage changes only at a rising `wclk` edge with `we` high. With `we` low, the data and address on the write port change nothing.
- R6: With `async_rd` low, `rd_data` takes the word at `raddr` at a rising `rclk` edge where `re` is high. Between such edges it does not follow `raddr`, and at an edge with `re` low it holds its value.
- R7: With `async_rd` high and `re` high, `rd_data` shows the word at `raddr` without waiting for a clock edge.
- R8: With `async_rd` high and `re` low, `rd_data` holds the word sampled at the last rising `rclk` edge where `re` was high.
- R9: A registered read at the same `rclk`/`wclk` edge as a write to the same address returns the word stored before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-port clock |
| rclk | input | 1 | Read-port clock |
| rst_n | input | 1 | Active-low asynchronous reset of the read register |
| org | input | 2 | Organization select: 0 128x18, 1 256x9, 2 512x4, 3 1024x2 |
| we | input | 1 | Write enable, clock enable on `wclk` |
| waddr | input | 10 | Write address |
| wdata | input | 18 | Write data, low W bits used |
| re | input | 1 | Read enable: load enable (registered) or path enable (flow-through) |
| async_rd | input | 1 | 1 selects flow-through read, 0 registered read |
| raddr | input | 10 | Read address |
| rd_data | output | 18 | Read data, zero above bit W-1 |

## Verification
The bench builds the block with its default parameters: 7 row-address bits and 18-bit rows, the full 2,304-bit array. At this size every word of every shape can be written and read back in both read styles. Each write drives the unused address bits high and the unused data bits with ones, so the ignored-bit rules are exercised on every access. Directed sequences then cover the enable-low cases, the flow-through hold and a read and write to the same address at one edge.

// File: rtl/cfg_dpram_pkg.sv
package cfg_dpram_pkg;

    localparam int ORG_COUNT = 4;

    typedef enum logic [1:0] {
        ORG_128X18  = 2'd0,
        ORG_256X9   = 2'd1,
        ORG_512X4   = 2'd2,
        ORG_1024X2  = 2'd3
    } org_e;

endpackage

// File: rtl/cfg_dpram_addr_map.sv
module cfg_dpram_addr_map
    import cfg_dpram_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int ROW_AW     = 7,
    parameter int LANE_SEL_W = 3
) (
    input  org_e                  org,
    input  logic [ADDR_W-1:0]     addr,
    output logic [ROW_AW-1:0]     row,
    output logic [LANE_SEL_W-1:0] lane
);

    logic [ADDR_W-1:0] shifted;
    logic [ADDR_W-1:0] lane_mask;

    always_comb begin
        // Low org bits pick the lane, the next ROW_AW bits pick the row;
        // any address bit above those is dropped here.
        shifted   = addr >> org;
        lane_mask = (ADDR_W'(1) << org) - ADDR_W'(1);
        row       = shifted[ROW_AW-1:0];
        lane      = LANE_SEL_W'(addr & lane_mask);
    end

endmodule

// File: rtl/cfg_dpram_array.sv
module cfg_dpram_array
    import cfg_dpram_pkg::*;
#(
    parameter int ROW_W      = 18,
    parameter int ROW_AW     = 7,
    parameter int LANE_SEL_W = 3,
    parameter int DATA_W     = 18
) (
    input  logic                  wclk,
    input  logic                  rst_n,
    input  org_e                  org,
    input  logic                  we,
    input  logic [ROW_AW-1:0]     wrow,
    input  logic [LANE_SEL_W-1:0] wlane,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [ROW_AW-1:0]     rrow,
    output logic [ROW_W-1:0]      rrow_bits
);

    localparam int ROWS = 1 << ROW_AW;

    typedef struct packed {
        logic [ROW_W-1:0] mask;
        logic [ROW_W-1:0] bits;
    } wr_plan_t;

    logic [ROW_W-1:0] mem [ROWS];
    wr_plan_t         plan;
    logic [ROW_W-1:0] row_d;
    logic [4:0]       lane_w;
    logic [7:0]       lane_off;
    logic [ROW_W:0]   wide_mask;
    logic [ROW_W-1:0] low_mask;

    always_comb begin
        lane_w    = 5'(ROW_W >> org);
        lane_off  = 8'(wlane) * 8'(lane_w);
        wide_mask = ((ROW_W+1)'(1) << lane_w) - (ROW_W+1)'(1);
        low_mask  = wide_mask[ROW_W-1:0];
        plan.mask = low_mask << lane_off;
        plan.bits = (ROW_W'(wdata) & low_mask) << lane_off;
        row_d     = (mem[wrow] & ~plan.mask) | plan.bits;
    end

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[wrow] <= row_d;
        end
    end

    assign rrow_bits = mem[rrow];

    // R5: an enabled write leaves exactly the planned lane bits in its row
    p_write_lands_r5: assert property (@(posedge wclk) disable iff (!rst_n)
        we |=> ((mem[$past(wrow)] & $past(plan.mask)) == $past(plan.bits)));

endmodule

// File: rtl/cfg_dpram_rd_port.sv
module cfg_dpram_rd_port
    import cfg_dpram_pkg::*;
#(
    parameter int ROW_W      = 18,
    parameter int LANE_SEL_W = 3,
    parameter int DATA_W     = 18
) (
    input  logic                  rclk,
    input  logic                  rst_n,
    input  org_e                  org,
    input  logic                  re,
    input  logic                  async_rd,
    input  logic [LANE_SEL_W-1:0] rlane,
    input  logic [ROW_W-1:0]      row_bits,
    output logic [DATA_W-1:0]     rd_data
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t        st_d;
    rd_state_t        st_q;
    logic [4:0]       lane_w;
    logic [7:0]       lane_off;
    logic [ROW_W:0]   wide_mask;
    logic [ROW_W-1:0] low_mask;
    logic [DATA_W-1:0] flow;

    always_comb begin
        lane_w    = 5'(ROW_W >> org);
        lane_off  = 8'(rlane) * 8'(lane_w);
        wide_mask = ((ROW_W+1)'(1) << lane_w) - (ROW_W+1)'(1);
        low_mask  = wide_mask[ROW_W-1:0];
        flow      = DATA_W'((row_bits >> lane_off) & low_mask);
    end

    // The same register serves both styles: it is the output in registered
    // style and the held value in flow-through style.
    always_comb begin
        st_d = st_q;
        if (re) begin
            st_d.data = flow;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = (async_rd && re) ? flow : st_q.data;

    // R6: an enabled registered read presents the word looked up before the edge
    p_sync_load_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        (re && !async_rd) |=> (async_rd || rd_data == $past(flow)));

    // R6: a registered read with enable low keeps its output
    p_sync_hold_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        (!re && !async_rd) |=> ((async_rd && re) || rd_data == $past(rd_data)));

    // R8: closing the flow-through path leaves the last sampled word
    p_async_hold_r8: assert property (@(posedge rclk) disable iff (!rst_n)
        (async_rd && re) |=> (re || !async_rd || rd_data == $past(flow)));

endmodule

// File: rtl/cfg_dpram.sv
module cfg_dpram
    import cfg_dpram_pkg::*;
#(
    parameter int ROW_W  = 18,
    parameter int ROW_AW = 7,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [1:0]        org,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic              async_rd,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int LANE_SEL_W = ORG_COUNT - 1;

    org_e                  org_sel;
    logic [ROW_AW-1:0]     wrow;
    logic [LANE_SEL_W-1:0] wlane;
    logic [ROW_AW-1:0]     rrow;
    logic [LANE_SEL_W-1:0] rlane;
    logic [ROW_W-1:0]      rrow_bits;

    assign org_sel = org_e'(org);

    cfg_dpram_addr_map #(
        .ADDR_W(ADDR_W), .ROW_AW(ROW_AW), .LANE_SEL_W(LANE_SEL_W)
    ) u_wmap (
        .org(org_sel), .addr(waddr), .row(wrow), .lane(wlane)
    );

    cfg_dpram_addr_map #(
        .ADDR_W(ADDR_W), .ROW_AW(ROW_AW), .LANE_SEL_W(LANE_SEL_W)
    ) u_rmap (
        .org(org_sel), .addr(raddr), .row(rrow), .lane(rlane)
    );

    cfg_dpram_array #(
        .ROW_W(ROW_W), .ROW_AW(ROW_AW), .LANE_SEL_W(LANE_SEL_W), .DATA_W(DATA_W)
    ) u_array (
        .wclk(wclk), .rst_n(rst_n), .org(org_sel), .we(we),
        .wrow(wrow), .wlane(wlane), .wdata(wdata),
        .rrow(rrow), .rrow_bits(rrow_bits)
    );

    cfg_dpram_rd_port #(
        .ROW_W(ROW_W), .LANE_SEL_W(LANE_SEL_W), .DATA_W(DATA_W)
    ) u_rd (
        .rclk(rclk), .rst_n(rst_n), .org(org_sel), .re(re),
        .async_rd(async_rd), .rlane(rlane), .row_bits(rrow_bits),
        .rd_data(rd_data)
    );

    // R1: the read output is cleared while reset is held
    p_reset_clear_r1: assert property (@(posedge rclk)
        !rst_n |-> rd_data == '0);

endmodule

// File: tb/cfg_dpram_tb.sv
module cfg_dpram_tb;

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  org = 2'd0;
    logic        we = 1'b0;
    logic [9:0]  waddr = '0;
    logic [17:0] wdata = '0;
    logic        re = 1'b0;
    logic        async_rd = 1'b0;
    logic [9:0]  raddr = '0;
    logic [17:0] rd_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 wclk = ~wclk;
    always #10 rclk = ~rclk;

    cfg_dpram u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .org(org), .we(we),
        .waddr(waddr), .wdata(wdata), .re(re), .async_rd(async_rd),
        .raddr(raddr), .rd_data(rd_data)
    );

    function automatic int width_of(int m);
        return 18 >> m;
    endfunction

    function automatic logic [17:0] low_mask(int m);
        return 18'((1 << width_of(m)) - 1);
    endfunction

    function automatic logic [17:0] pattern(int m, int a);
        return 18'((a * 37 + m * 1000 + 11) ^ (a << 5));
    endfunction

    task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sweep(int m);
        int depth;
        logic [9:0] hi_bits;
        depth   = 128 << m;
        hi_bits = 10'h3FF & ~10'((1 << (7 + m)) - 1);
        @(negedge wclk);
        org = 2'(m);
        re = 1'b0;
        async_rd = 1'b0;
        // R3: unused address bits high, unused data bits all ones
        for (int a = 0; a < depth; a++) begin
            we    = 1'b1;
            waddr = 10'(a) | hi_bits;
            wdata = pattern(m, a) | ~low_mask(m);
            @(negedge wclk);
        end
        we = 1'b0;
        // R2 R3 R4 R6: registered read of every word
        re = 1'b1;
        for (int a = 0; a < depth; a++) begin
            raddr = 10'(a);
            @(negedge rclk);
            chk("R2 R3 R4 R6 registered sweep", rd_data, pattern(m, a) & low_mask(m));
        end
        // R7: flow-through read of every word
        async_rd = 1'b1;
        for (int a = 0; a < depth; a++) begin
            raddr = 10'(depth - 1 - a);
            #2;
            chk("R2 R7 flow-through sweep", rd_data, pattern(m, depth - 1 - a) & low_mask(m));
        end
        @(negedge rclk);
        re = 1'b0;
        async_rd = 1'b0;
    endtask

    task automatic write_word(logic [9:0] a, logic [17:0] d);
        @(negedge wclk);
        we = 1'b1;
        waddr = a;
        wdata = d;
        @(negedge wclk);
        we = 1'b0;
    endtask

    task automatic sync_read(logic [9:0] a, logic [17:0] exp, string tag);
        @(negedge rclk);
        async_rd = 1'b0;
        re = 1'b1;
        raddr = a;
        @(negedge rclk);
        chk(tag, rd_data, exp);
        re = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge rclk);
        chk("R1 output during reset", rd_data, 18'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge rclk);
        chk("R1 output after reset", rd_data, 18'h0);

        for (int m = 0; m < 4; m++) begin
            sweep(m);
        end

        // Directed cases in the 128x18 shape
        @(negedge wclk);
        org = 2'd0;
        write_word(10'd5,  18'h2A5A5);
        write_word(10'd9,  18'h01234);
        write_word(10'd20, 18'h3C3C3);

        // R5: disabled write does not touch word 5
        @(negedge wclk);
        we = 1'b0;
        waddr = 10'd5;
        wdata = 18'h11111;
        @(negedge wclk);
        sync_read(10'd5, 18'h2A5A5, "R5 write with enable low");

        // R9: same-edge write and registered read of word 9
        @(negedge wclk);
        waddr = 10'd9;
        wdata = 18'h0FEDC;
        we = 1'b1;
        raddr = 10'd9;
        re = 1'b1;
        async_rd = 1'b0;
        @(negedge rclk);
        chk("R9 old word on collision", rd_data, 18'h01234);
        we = 1'b0;
        @(negedge rclk);
        chk("R9 new word next read", rd_data, 18'h0FEDC);

        // R6: no change between edges, hold when enable low
        raddr = 10'd20;
        #2;
        chk("R6 no change before edge", rd_data, 18'h0FEDC);
        re = 1'b0;
        @(negedge rclk);
        chk("R6 hold with enable low", rd_data, 18'h0FEDC);
        re = 1'b1;
        @(negedge rclk);
        chk("R6 load with enable high", rd_data, 18'h3C3C3);

        // R7 R8: flow-through then hold
        async_rd = 1'b1;
        raddr = 10'd5;
        #2;
        chk("R7 flow-through without edge", rd_data, 18'h2A5A5);
        @(negedge rclk);
        re = 1'b0;
        raddr = 10'd20;
        #2;
        chk("R8 hold after path closed", rd_data, 18'h2A5A5);
        @(negedge rclk);
        chk("R8 hold across edge", rd_data, 18'h2A5A5);
        re = 1'b1;
        #2;
        chk("R7 path reopened", rd_data, 18'h3C3C3);
        @(negedge rclk);
        re = 1'b0;
        async_rd = 1'b0;

        // R4: 512x4 shape, all-ones data keeps upper read bits zero
        @(negedge wclk);
        org = 2'd2;
        write_word(10'd3, 18'h3FFFF);
        sync_read(10'd3, 18'h0000F, "R4 upper bits zero");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule